// File: doc/BRIEF.md
# Subvector Element Swizzle Engine

The engine rearranges short packed subvectors held in a flat byte-addressed register store. The source vector is a sequence of VL groups. Each source group holds between one and four scalars. The destination vector is also a sequence of VL groups, and each destination group holds its own count of scalars, again between one and four. Every destination slot receives a copy of one scalar from the matching source group. A small constant index per destination slot, taken from the instruction, chooses which scalar that is. Because the indices are free, one launch can duplicate scalars, reorder them, or pick a single lane out of every group. Scalars are 8, 16 or 32 bits wide.

A launch is a one-cycle `start` pulse. With that pulse the engine captures the group count, both group lengths, the element width, the selector list and the two base addresses. It then walks the destination scalars one per clock. For each scalar it reads the chosen source scalar through an asynchronous read port and issues a registered byte-strobed write. It signals completion with a one-cycle `done` pulse. If the configuration is illegal, the engine reports `err` together with `done` and writes nothing.

The controller uses five named states:
- `S_IDLE` waits for `start`.
- `S_RUN` issues one scalar per cycle.
- `S_DRAIN` holds the final write on the port.
- `S_FINISH` pulses `done`.
- `S_FAULT` pulses `done` and `err` together.

The transitions are:
- idle to fault when the configuration is illegal.
- idle to finish when VL is zero.
- idle to run otherwise.
- run stays in run until the last scalar is issued, then goes to drain.
- drain to finish.
- finish to idle, and fault to idle.

Top module: `swz_engine`

## Requirements
- R1: For group g (0..VL-1) and destination slot k (0..dst_len-1), the destination scalar at byte address dst_base + (g*dst_len + k)*B is a copy of the source scalar at src_base + (g*src_len + sel_k)*B. B is the element size in bytes. Scalars are stored little-endian. The selector for slot k is `sel[2k+1:2k]`.
- R2: src_len and dst_len are independent. A launch with 3 source scalars and 4 destination scalars per group fills all 4 destination slots of every group.
- R3: Several slots may carry the same selector value, and each such slot receives the same source scalar.
- R4: With dst_len = 1, exactly one scalar per group is written: the selected lane of that group.
- R5: ew encodes the element width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Each write carries wr_strb = 4'b0001, 4'b0011 or 4'b1111 to match, and bytes outside the strobe are never modified.
- R6: Exactly VL*dst_len writes are made, one per consecutive cycle. They run in increasing group order and then increasing slot order, so each write address exceeds the previous one by B. The first write appears two cycles after the cycle in which start is sampled.
- R7: done is a single-cycle pulse in the cycle right after the last write, and it never coincides with a write.
- R8: A launch with VL = 0 makes no write and raises done in the cycle after start is sampled.
- R9: If any slot k < dst_len has sel_k >= src_len, the launch makes no write and raises done and err together in the cycle after start. Selectors of slots k >= dst_len are ignored.
- R10: A src_len or dst_len outside 1..4, or ew = 3, is treated like R9: no write, with done and err.
- R11: While busy, start and all configuration inputs are ignored. The running launch completes with the values captured at its start.
- R12: After reset, busy, done, err and wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled only when idle |
| vl | input | VLW | Number of groups |
| src_len | input | LENW | Scalars per source group (1..4) |
| dst_len | input | LENW | Scalars per destination group (1..4) |
| ew | input | 2 | Element width code |
| sel | input | MAXLEN*SELW | Per-slot source lane indices, slot k at bits [2k+1:2k] |
| src_base | input | AW | Byte address of the source vector |
| dst_base | input | AW | Byte address of the destination vector |
| rd_addr | output | AW | Byte address of the scalar being read |
| rd_data | input | 32 | Four bytes starting at rd_addr, little-endian, same cycle |
| wr_en | output | 1 | Write valid |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | 32 | Write data, low bytes significant |
| wr_strb | output | 4 | Byte enables, bit j for wr_addr+j |
| busy | output | 1 | A launch is in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal configuration, high with done |

## Verification
The bench targets several corner cases, each of which catches a specific kind of design error:
- A 3-in/4-out launch with a repeated selector. A design that tied the group stride to the wrong length, or that read lanes sequentially, would shift groups or drop the duplicate.
- Single-lane extraction at 32 bits.
- A 16-bit reorder. A wrong strobe or byte shift would damage neighbouring bytes, and the whole store is compared after every launch to catch this.
- A zero VL, an out-of-range selector, and an unused out-of-range selector beyond dst_len. A design that checked all four slots would wrongly fault, and one that checked none would write garbage.
- Illegal lengths and widths.
- A launch at the maximum VL, where an early or late last-scalar decode would miscount writes.
- A second start with different settings issued mid-run. A design that re-samples live inputs would write to the wrong place.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RUN,
        S_DRAIN,
        S_FINISH,
        S_FAULT
    } swz_state_e;

    localparam logic [1:0] EW_8  = 2'd0;
    localparam logic [1:0] EW_16 = 2'd1;
    localparam logic [1:0] EW_32 = 2'd2;

    function automatic logic [1:0] ew_shift(input logic [1:0] ew);
        case (ew)
            EW_32:   return 2'd2;
            EW_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [3:0] ew_strb(input logic [1:0] ew);
        case (ew)
            EW_32:   return 4'b1111;
            EW_16:   return 4'b0011;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [31:0] ew_mask(input logic [1:0] ew);
        case (ew)
            EW_32:   return 32'hFFFF_FFFF;
            EW_16:   return 32'h0000_FFFF;
            default: return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/swz_check.sv
module swz_check #(
    parameter int MAXLEN = 4,
    parameter int SELW   = 2,
    parameter int LENW   = 3
) (
    input  logic [LENW-1:0]        slen,
    input  logic [LENW-1:0]        dlen,
    input  logic [1:0]             ew,
    input  logic [MAXLEN*SELW-1:0] sel,
    output logic                   ok
);
    logic [MAXLEN-1:0] bad;

    for (genvar k = 0; k < MAXLEN; k++) begin : g_slot
        // only slots that will actually be written are validated
        assign bad[k] = (LENW'(k) < dlen) && (LENW'(sel[k*SELW +: SELW]) >= slen);
    end

    logic slen_ok, dlen_ok, ew_ok;
    assign slen_ok = (slen != '0) && (slen <= LENW'(MAXLEN));
    assign dlen_ok = (dlen != '0) && (dlen <= LENW'(MAXLEN));
    assign ew_ok   = (ew != 2'd3);
    assign ok      = slen_ok && dlen_ok && ew_ok && (bad == '0);
endmodule

// File: rtl/swz_cursor.sv
module swz_cursor #(
    parameter int VLW  = 6,
    parameter int SELW = 2,
    parameter int LENW = 3,
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    input  logic [VLW-1:0]  vl,
    input  logic [LENW-1:0] slen,
    input  logic [LENW-1:0] dlen,
    output logic [SELW-1:0] slot,
    output logic [IDXW-1:0] sgrp_idx,
    output logic [IDXW-1:0] didx,
    output logic            last
);
    logic [VLW-1:0]  grp_q;
    logic [SELW-1:0] slot_q;
    logic [IDXW-1:0] sgrp_q;
    logic [IDXW-1:0] didx_q;
    logic            slot_end;
    logic            grp_end;

    assign slot_end = (LENW'(slot_q) == dlen - LENW'(1));
    assign grp_end  = (grp_q == vl - VLW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            grp_q  <= '0;
            slot_q <= '0;
            sgrp_q <= '0;
            didx_q <= '0;
        end else if (step) begin
            didx_q <= didx_q + IDXW'(1);
            if (slot_end) begin
                slot_q <= '0;
                grp_q  <= grp_q + VLW'(1);
                sgrp_q <= sgrp_q + IDXW'(slen);
            end else begin
                slot_q <= slot_q + SELW'(1);
            end
        end
    end

    assign slot     = slot_q;
    assign sgrp_idx = sgrp_q;
    assign didx     = didx_q;
    assign last     = slot_end && grp_end;
endmodule

// File: rtl/swz_addr.sv
module swz_addr #(
    parameter int AW   = 12,
    parameter int SELW = 2,
    parameter int IDXW = 8
) (
    input  logic [AW-1:0]   src_base,
    input  logic [AW-1:0]   dst_base,
    input  logic [IDXW-1:0] sgrp_idx,
    input  logic [SELW-1:0] lane,
    input  logic [IDXW-1:0] didx,
    input  logic [1:0]      shift,
    output logic [AW-1:0]   src_addr,
    output logic [AW-1:0]   dst_addr
);
    logic [IDXW+1:0] s_off;
    logic [IDXW+1:0] d_off;

    assign s_off    = {2'b00, sgrp_idx + IDXW'(lane)} << shift;
    assign d_off    = {2'b00, didx} << shift;
    assign src_addr = src_base + AW'(s_off);
    assign dst_addr = dst_base + AW'(d_off);
endmodule

// File: rtl/swz_engine.sv
module swz_engine #(
    parameter int AW     = 12,
    parameter int VLW    = 6,
    parameter int MAXLEN = 4,
    parameter int SELW   = $clog2(MAXLEN),
    parameter int LENW   = $clog2(MAXLEN + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [VLW-1:0]         vl,
    input  logic [LENW-1:0]        src_len,
    input  logic [LENW-1:0]        dst_len,
    input  logic [1:0]             ew,
    input  logic [MAXLEN*SELW-1:0] sel,
    input  logic [AW-1:0]          src_base,
    input  logic [AW-1:0]          dst_base,
    output logic [AW-1:0]          rd_addr,
    input  logic [31:0]            rd_data,
    output logic                   wr_en,
    output logic [AW-1:0]          wr_addr,
    output logic [31:0]            wr_data,
    output logic [3:0]             wr_strb,
    output logic                   busy,
    output logic                   done,
    output logic                   err
);
    import swz_pkg::*;

    localparam int IDXW = VLW + SELW;

    swz_state_e state, nxt;

    logic                   cfg_ok;
    logic                   accept;
    logic [VLW-1:0]         vl_q;
    logic [LENW-1:0]        slen_q;
    logic [LENW-1:0]        dlen_q;
    logic [1:0]             ew_q;
    logic [MAXLEN*SELW-1:0] sel_q;
    logic [AW-1:0]          sbase_q;
    logic [AW-1:0]          dbase_q;

    logic [SELW-1:0] slot;
    logic [IDXW-1:0] sgrp_idx;
    logic [IDXW-1:0] didx;
    logic            last;
    logic [SELW-1:0] lane;
    logic [AW-1:0]   src_addr;
    logic [AW-1:0]   dst_addr;

    assign accept = (state == S_IDLE) && start;

    swz_check #(.MAXLEN(MAXLEN), .SELW(SELW), .LENW(LENW)) i_check (
        .slen (src_len),
        .dlen (dst_len),
        .ew   (ew),
        .sel  (sel),
        .ok   (cfg_ok)
    );

    // launch settings are captured once; live inputs are ignored afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q    <= '0;
            slen_q  <= LENW'(1);
            dlen_q  <= LENW'(1);
            ew_q    <= EW_8;
            sel_q   <= '0;
            sbase_q <= '0;
            dbase_q <= '0;
        end else if (accept) begin
            vl_q    <= vl;
            slen_q  <= src_len;
            dlen_q  <= dst_len;
            ew_q    <= ew;
            sel_q   <= sel;
            sbase_q <= src_base;
            dbase_q <= dst_base;
        end
    end

    swz_cursor #(.VLW(VLW), .SELW(SELW), .LENW(LENW), .IDXW(IDXW)) i_cursor (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     (state == S_RUN),
        .vl       (vl_q),
        .slen     (slen_q),
        .dlen     (dlen_q),
        .slot     (slot),
        .sgrp_idx (sgrp_idx),
        .didx     (didx),
        .last     (last)
    );

    assign lane = sel_q[slot*SELW +: SELW];

    swz_addr #(.AW(AW), .SELW(SELW), .IDXW(IDXW)) i_addr (
        .src_base (sbase_q),
        .dst_base (dbase_q),
        .sgrp_idx (sgrp_idx),
        .lane     (lane),
        .didx     (didx),
        .shift    (ew_shift(ew_q)),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    assign rd_addr = src_addr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!cfg_ok)        nxt = S_FAULT;
                    else if (vl == '0)  nxt = S_FINISH;
                    else                nxt = S_RUN;
                end
            end
            S_RUN:    if (last) nxt = S_DRAIN;
            S_DRAIN:  nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            S_FAULT:  nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // write port: one registered scalar per run cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            wr_en <= (state == S_RUN);
            if (state == S_RUN) begin
                wr_addr <= dst_addr;
                wr_data <= rd_data & ew_mask(ew_q);
                wr_strb <= ew_strb(ew_q);
            end
        end
    end

    // status outputs
    always_comb begin
        busy = (state != S_IDLE);
        done = 1'b0;
        err  = 1'b0;
        unique case (state)
            S_FINISH: done = 1'b1;
            S_FAULT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/swz_engine_chk.sv
module swz_engine_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [3:0]    wr_strb,
    input logic          busy,
    input logic          done,
    input logic          err
);
    assert_strb_legal_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_strb == 4'b0001 || wr_strb == 4'b0011 || wr_strb == 4'b1111));

    assert_write_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    assert_addr_stride_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |->
            (wr_addr == $past(wr_addr) + AW'($countones($past(wr_strb)))));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_en && !done));
endmodule

bind swz_engine swz_engine_chk #(.AW(AW)) i_swz_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_strb (wr_strb),
    .busy    (busy),
    .done    (done),
    .err     (err)
);

// File: tb/test_swz_engine.sv
module test_swz_engine;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  vl = '0;
    logic [2:0]  src_len = 3'd1;
    logic [2:0]  dst_len = 3'd1;
    logic [1:0]  ew = 2'd0;
    logic [7:0]  sel = '0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] dst_base = '0;
    logic [AW-1:0] rd_addr;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [AW-1:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;
    logic        busy, done, err;

    logic [7:0] mem [256];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nwr, ndone, first_wr, last_wr, done_cyc;
    bit err_seen;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign rd_data = {mem[rd_addr + 8'd3], mem[rd_addr + 8'd2],
                      mem[rd_addr + 8'd1], mem[rd_addr]};

    swz_engine #(.AW(AW)) i_swz_engine (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .src_len(src_len),
        .dst_len(dst_len), .ew(ew), .sel(sel), .src_base(src_base),
        .dst_base(dst_base), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .busy(busy), .done(done), .err(err)
    );

    // monitor: applies writes to the store model and records timing
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                for (int j = 0; j < 4; j++)
                    if (wr_strb[j]) mem[wr_addr + AW'(j)] = wr_data[8*j +: 8];
                if (nwr == 0) first_wr = cyc;
                last_wr = cyc;
                nwr++;
            end
            if (done) begin
                ndone++;
                done_cyc = cyc;
                err_seen = err;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic run_op(input string req, input int v, input int sl, input int dl,
                          input int w, input logic [7:0] sp, input int sb, input int db,
                          input bit bad, input bit poke);
        logic [7:0] expm [256];
        int nb, scyc, mism;
        for (int i = 0; i < 256; i++) begin
            mem[i] = pat(i);
            expm[i] = pat(i);
        end
        nb = (w == 2) ? 4 : (w == 1) ? 2 : 1;
        if (!bad)
            for (int g = 0; g < v; g++)
                for (int k = 0; k < dl; k++)
                    for (int b = 0; b < nb; b++)
                        expm[(db + (g*dl + k)*nb + b) & 255] =
                            pat((sb + (g*sl + int'(sp[2*k +: 2]))*nb + b) & 255);
        @(negedge clk);
        nwr = 0; ndone = 0; first_wr = -1; last_wr = -1; done_cyc = -1; err_seen = 0;
        vl = 6'(v); src_len = 3'(sl); dst_len = 3'(dl); ew = 2'(w); sel = sp;
        src_base = AW'(sb); dst_base = AW'(db);
        start = 1'b1;
        scyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            vl = 6'd9; src_len = 3'd1; dst_len = 3'd1; ew = 2'd3; sel = 8'hFF;
            src_base = 8'd200; dst_base = 8'd240;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 2000 && ndone == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(req, "done count", ndone, 1);
        check(req, "err flag", int'(err_seen), int'(bad));
        if (bad || v == 0) begin
            check(req, "write count", nwr, 0);
            check(req, "done cycle", done_cyc, scyc + 1);
        end else begin
            check(req, "write count", nwr, v * dl);
            check(req, "first write cycle", first_wr, scyc + 2);
            check(req, "done after last write", done_cyc, last_wr + 1);
        end
        mism = 0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== expm[i]) begin
                if (mism == 0)
                    $display("FAIL %s byte %0d: actual %0d expected %0d", req, i, mem[i], expm[i]);
                mism++;
            end
        checks++;
        if (mism != 0) errors++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", "busy after reset", int'(busy), 0);
        check("R12", "done after reset", int'(done), 0);
        check("R12", "wr_en after reset", int'(wr_en), 0);
        check("R12", "err after reset", int'(err), 0);
        // R1 R2 R3: 3 in, 4 out, selectors {1,2,0,0} slot0 in low bits
        run_op("R2", 5, 3, 4, 0, {2'd1, 2'd2, 2'd0, 2'd0}, 0, 100, 0, 0);
        run_op("R3", 4, 2, 4, 0, {2'd1, 2'd1, 2'd1, 2'd1}, 10, 60, 0, 0);
        // R4 R5: extract lane 2 of 32-bit groups
        run_op("R4", 5, 4, 1, 2, {6'd0, 2'd2}, 0, 120, 0, 0);
        // R5: 16-bit reorder
        run_op("R5", 6, 2, 2, 1, {4'd0, 2'd0, 2'd1}, 2, 101, 0, 0);
        // R1: 32-bit, 1 in -> 3 out broadcast
        run_op("R1", 3, 1, 3, 2, 8'h00, 16, 64, 0, 0);
        // R8: zero groups
        run_op("R8", 0, 2, 2, 0, 8'h00, 0, 50, 0, 0);
        // R9: slot 3 selects lane 3 of a 3-lane group
        run_op("R9", 2, 3, 4, 0, {2'd3, 2'd0, 2'd1, 2'd2}, 0, 50, 1, 0);
        // R9: same bad selector in slot 3 but dst_len 2 makes it unused
        run_op("R9", 3, 2, 2, 0, {2'd3, 2'd3, 2'd1, 2'd0}, 0, 50, 0, 0);
        // R10: illegal lengths and width
        run_op("R10", 2, 0, 2, 0, 8'h00, 0, 50, 1, 0);
        run_op("R10", 2, 2, 5, 0, 8'h00, 0, 50, 1, 0);
        run_op("R10", 2, 2, 2, 3, 8'h00, 0, 50, 1, 0);
        // R6: maximum group count
        run_op("R6", 63, 1, 1, 0, 8'h00, 0, 128, 0, 0);
        // R11: start and new settings during a run are ignored
        run_op("R11", 8, 3, 2, 0, {4'd0, 2'd0, 2'd2}, 0, 150, 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule